// File: doc/BRIEF.md
# Software-Pipeline Loop Branch Controller

This block steers a kernel-only software-pipelined loop. One copy of the loop body, the kernel, is executed on every pass. Each operation in it is guarded by one bit of a staging-predicate vector. The controller keeps two down-counters: an iteration counter, loaded with the trip count minus one, and a drain counter, loaded with the stage count minus one. It also keeps the predicate vector. At the end of each pass the sequencer pulses a branch strobe. The controller then decides whether the loop branches back and moves its state forward.

While iterations remain, each branch starts a new iteration. The predicates shift up by one place and a 1 enters at the bottom. After the last iteration has started, each branch drains one stage: a 0 enters instead and the drain counter counts down. When both counters are zero, the next branch falls through and the loop ends. Prologue, kernel and epilogue therefore all run from the same code. A loop of N iterations over S stages takes N+S-1 passes. Each taken branch also pulses a rotate strobe for an attached rotating register file.

Top module: `swp_loop_ctrl`

## Requirements
- R1: After reset, `busy_o`, `taken_o` and `rotate_o` are 0, and `pred_o`, `loop_cnt_o` and `epi_cnt_o` are all zero.
- R2: A cycle with `init_i` high loads `loop_cnt_o` with `iter_last_i` (N-1) and `epi_cnt_o` with `stage_last_i` (S-1). It sets `pred_o` to only bit 0 high and raises `busy_o`, all in the next cycle. `init_i` takes precedence over `br_i` and restarts a loop that is already running.
- R3: A branch strobe while busy with `loop_cnt_o` > 0 decrements `loop_cnt_o` by one. In the same step `pred_o[k]` takes the old `pred_o[k-1]` and `pred_o[0]` becomes 1. `taken_o` and `rotate_o` are high for exactly the following cycle.
- R4: A branch strobe while busy with `loop_cnt_o` = 0 and `epi_cnt_o` > 0 decrements `epi_cnt_o` by one. The predicates shift up as in R3, but `pred_o[0]` becomes 0. `taken_o` and `rotate_o` are high for exactly the following cycle.
- R5: A branch strobe while busy with both counters at zero is not taken. `taken_o` and `rotate_o` stay 0, `busy_o` drops in the next cycle, and the counters and predicates hold.
- R6: A branch strobe while `busy_o` is 0 is ignored: no taken or rotate pulse, and no change of counters or predicates.
- R7: A loop of N iterations and S stages executes N+S-1 kernel passes, i.e. N+S-2 taken branches. For N=4 and S=4, `pred_o` steps through 0001, 0011, 0111, 1111, 1110, 1100, 1000, where bit 0 is the rightmost digit.
- R8: In a cycle without `br_i` or `init_i`, all state holds and `taken_o` and `rotate_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Load counters and seed the predicates |
| iter_last_i | input | LC_W | Trip count minus one |
| stage_last_i | input | SC_W | Stage count minus one (at most STAGES-1) |
| br_i | input | 1 | Branch-execute strobe, one per kernel pass |
| taken_o | output | 1 | Branch taken, one cycle after the strobe |
| rotate_o | output | 1 | Register-file rotate pulse, one cycle after the strobe |
| busy_o | output | 1 | Loop active, from init until fall-through |
| pred_o | output | STAGES | Staging predicates, bit k guards stage k |
| loop_cnt_o | output | LC_W | Remaining iteration counter |
| epi_cnt_o | output | SC_W | Remaining drain counter |

## Verification
Every result of this block is registered once. The effect of `init_i` or `br_i` presented before edge E is visible on all outputs just after edge E, and a taken pulse lasts exactly that one cycle. The driver applies inputs just after an edge and computes the expected outputs from the requirements. It queues them stamped with the cycle count of the following edge, and the monitor compares them only at the falling edge of that cycle. Taken pulses are also counted over whole loops and checked against N+S-2 for several pairs of N and S, including N=1 and S=1.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_FILL  = 2'd1,
    ACT_DRAIN = 2'd2,
    ACT_EXIT  = 2'd3
  } br_act_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/swp_down_counter.sv
module swp_down_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_i) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R3 R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |-> (cnt_o != '0));

  // R3 R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |=> (cnt_o == $past(cnt_o) - W'(1)));

endmodule

// File: rtl/swp_branch_decide.sv
module swp_branch_decide
  import swp_pkg::*;
(
  input  logic    busy_i,
  input  logic    br_i,
  input  logic    init_i,
  input  logic    lc_zero_i,
  input  logic    esc_zero_i,
  output br_act_e act_o,
  output logic    fill_o,
  output logic    drain_o,
  output logic    leave_o
);

  always_comb begin
    if (init_i || !busy_i || !br_i) begin
      act_o = ACT_HOLD;
    end else if (!lc_zero_i) begin
      act_o = ACT_FILL;
    end else if (!esc_zero_i) begin
      act_o = ACT_DRAIN;
    end else begin
      act_o = ACT_EXIT;
    end
  end

  assign fill_o  = (act_o == ACT_FILL);
  assign drain_o = (act_o == ACT_DRAIN);
  assign leave_o = (act_o == ACT_EXIT);

endmodule

// File: rtl/swp_stage_preds.sv
module swp_stage_preds #(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              shift_i,
  input  logic              fill_bit_i,
  output logic [STAGES-1:0] pred_o
);

  logic [STAGES-1:0] pred_q;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_bit
      if (k == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) begin
            pred_q[0] <= 1'b0;
          end else if (init_i) begin
            pred_q[0] <= 1'b1;
          end else if (shift_i) begin
            pred_q[0] <= fill_bit_i;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) begin
            pred_q[k] <= 1'b0;
          end else if (init_i) begin
            pred_q[k] <= 1'b0;
          end else if (shift_i) begin
            pred_q[k] <= pred_q[k-1];
          end
        end

        // R3 R4
        shift_up_chk: assert property (@(posedge clk) disable iff (rst)
          (shift_i && !init_i) |=> (pred_o[k] == $past(pred_o[k-1])));
      end
    end
  endgenerate

  assign pred_o = pred_q;

  // R3 R4
  head_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !init_i) |=> (pred_o[0] == $past(fill_bit_i)));

endmodule

// File: rtl/swp_loop_ctrl.sv
module swp_loop_ctrl
  import swp_pkg::*;
#(
  parameter int unsigned STAGES = 4,
  parameter int unsigned LC_W   = 16,
  localparam int unsigned SC_W  = cnt_width(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic [LC_W-1:0]   iter_last_i,
  input  logic [SC_W-1:0]   stage_last_i,
  input  logic              br_i,
  output logic              taken_o,
  output logic              rotate_o,
  output logic              busy_o,
  output logic [STAGES-1:0] pred_o,
  output logic [LC_W-1:0]   loop_cnt_o,
  output logic [SC_W-1:0]   epi_cnt_o
);

  br_act_e act;
  logic    fill, drain, leave;
  logic    lc_zero, esc_zero;
  logic    busy_q, taken_q, rotate_q;

  swp_branch_decide u_decide (
    .busy_i     (busy_q),
    .br_i       (br_i),
    .init_i     (init_i),
    .lc_zero_i  (lc_zero),
    .esc_zero_i (esc_zero),
    .act_o      (act),
    .fill_o     (fill),
    .drain_o    (drain),
    .leave_o    (leave)
  );

  swp_down_counter #(.W(LC_W)) u_iter_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (init_i),
    .load_val_i (iter_last_i),
    .dec_i      (fill),
    .cnt_o      (loop_cnt_o),
    .zero_o     (lc_zero)
  );

  swp_down_counter #(.W(SC_W)) u_drain_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (init_i),
    .load_val_i (stage_last_i),
    .dec_i      (drain),
    .cnt_o      (epi_cnt_o),
    .zero_o     (esc_zero)
  );

  swp_stage_preds #(.STAGES(STAGES)) u_preds (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init_i),
    .shift_i    (fill | drain),
    .fill_bit_i (fill),
    .pred_o     (pred_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      taken_q  <= 1'b0;
      rotate_q <= 1'b0;
    end else begin
      taken_q  <= fill | drain;
      rotate_q <= fill | drain;
      if (init_i) begin
        busy_q <= 1'b1;
      end else if (leave) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o   = busy_q;
  assign taken_o  = taken_q;
  assign rotate_o = rotate_q;

  // R2
  init_seed_chk: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (busy_o && (pred_o == STAGES'(1)) && !taken_o));

  // R3
  taken_cause_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> ($past(br_i) && $past(busy_o) && !$past(init_i)));

  // R5
  exit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(br_i) && !taken_o && !rotate_o));

  // R6
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !init_i) |=> (!taken_o && $stable(pred_o) && $stable(loop_cnt_o) && $stable(epi_cnt_o)));

  // R8
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_i && !init_i) |=> (!taken_o && !rotate_o && $stable(pred_o) && $stable(busy_o)));

endmodule

// File: tb/swp_loop_ctrl_test.sv
`timescale 1ns/1ps
module swp_loop_ctrl_test;

  localparam int unsigned STAGES = 4;
  localparam int unsigned LC_W   = 16;
  localparam int unsigned SC_W   = 2;

  typedef struct {
    int              due;
    logic            taken;
    logic            busy;
    logic [LC_W-1:0] lc;
    logic [SC_W-1:0] esc;
    logic [STAGES-1:0] pred;
    string           tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              init_i = 1'b0;
  logic [LC_W-1:0]   iter_last_i = '0;
  logic [SC_W-1:0]   stage_last_i = '0;
  logic              br_i = 1'b0;
  logic              taken_o, rotate_o, busy_o;
  logic [STAGES-1:0] pred_o;
  logic [LC_W-1:0]   loop_cnt_o;
  logic [SC_W-1:0]   epi_cnt_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int taken_seen = 0;
  exp_t q[$];

  logic              m_busy = 1'b0;
  logic [LC_W-1:0]   m_lc   = '0;
  logic [SC_W-1:0]   m_esc  = '0;
  logic [STAGES-1:0] m_pred = '0;

  swp_loop_ctrl #(.STAGES(STAGES), .LC_W(LC_W)) uut (
    .clk(clk), .rst(rst), .init_i(init_i), .iter_last_i(iter_last_i),
    .stage_last_i(stage_last_i), .br_i(br_i), .taken_o(taken_o),
    .rotate_o(rotate_o), .busy_o(busy_o), .pred_o(pred_o),
    .loop_cnt_o(loop_cnt_o), .epi_cnt_o(epi_cnt_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    if (!rst && taken_o) taken_seen = taken_seen + 1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (taken_o !== e.taken || rotate_o !== e.taken || busy_o !== e.busy ||
          loop_cnt_o !== e.lc || epi_cnt_o !== e.esc || pred_o !== e.pred) begin
        n_bad++;
        $display("FAIL %s: got taken=%b rot=%b busy=%b lc=%0d esc=%0d pred=%b exp taken=%b rot=%b busy=%b lc=%0d esc=%0d pred=%b",
                 e.tag, taken_o, rotate_o, busy_o, loop_cnt_o, epi_cnt_o, pred_o,
                 e.taken, e.taken, e.busy, e.lc, e.esc, e.pred);
      end
    end
  end

  task automatic step(input bit ini, input int n1, input int s1, input bit br, input string tag);
    exp_t e;
    logic tk;
    @(posedge clk);
    #1;
    init_i = ini;
    iter_last_i = LC_W'(n1);
    stage_last_i = SC_W'(s1);
    br_i = br;
    tk = 1'b0;
    if (ini) begin
      m_lc = LC_W'(n1); m_esc = SC_W'(s1); m_pred = STAGES'(1); m_busy = 1'b1;
    end else if (br && m_busy) begin
      if (m_lc != 0) begin
        m_lc = m_lc - 1; m_pred = {m_pred[STAGES-2:0], 1'b1}; tk = 1'b1;
      end else if (m_esc != 0) begin
        m_esc = m_esc - 1; m_pred = {m_pred[STAGES-2:0], 1'b0}; tk = 1'b1;
      end else begin
        m_busy = 1'b0;
      end
    end
    e.due = cyc + 1; e.taken = tk; e.busy = m_busy; e.lc = m_lc;
    e.esc = m_esc; e.pred = m_pred; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check_count(input int got, input int expv, input string tag);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  // R7: whole loop, branch each cycle (or every other cycle), count taken pulses
  task automatic run_loop(input int n, input int s, input bit gaps);
    step(1'b1, n - 1, s - 1, 1'b0, "R2 init");
    step(1'b0, 0, 0, 1'b0, "R8 hold after init");
    taken_seen = 0;
    for (int i = 0; i < n + s - 1; i++) begin
      step(1'b0, 0, 0, 1'b1, "R3 R4 R5 R7 branch");
      if (gaps) step(1'b0, 0, 0, 1'b0, "R8 gap");
    end
    step(1'b0, 0, 0, 1'b0, "R5 after exit");
    step(1'b0, 0, 0, 1'b0, "R5 after exit");
    check_count(taken_seen, n + s - 2, "R7 taken count");
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    step(1'b0, 0, 0, 1'b0, "R1 reset state");
    step(1'b0, 0, 0, 1'b1, "R6 idle branch after reset");
    step(1'b0, 0, 0, 1'b0, "R6 idle branch after reset");
    // R7: 4 iterations, 4 stages: pattern 0001,0011,0111,1111,1110,1100,1000
    run_loop(4, 4, 1'b0);
    step(1'b0, 0, 0, 1'b1, "R6 idle branch after exit");
    run_loop(1, 4, 1'b0);
    run_loop(3, 2, 1'b1);
    run_loop(2, 1, 1'b0);
    run_loop(1, 1, 1'b0);
    run_loop(300, 3, 1'b0);
    // R2: init with branch in same cycle, init wins; restart mid-loop
    step(1'b1, 5, 3, 1'b1, "R2 init beats branch");
    step(1'b0, 0, 0, 1'b1, "R3 fill");
    step(1'b0, 0, 0, 1'b1, "R3 fill");
    step(1'b1, 1, 2, 1'b0, "R2 restart while busy");
    step(1'b0, 0, 0, 1'b1, "R3 fill");
    step(1'b0, 0, 0, 1'b1, "R4 drain");
    step(1'b0, 0, 0, 1'b0, "R8 hold in drain");
    step(1'b0, 0, 0, 1'b1, "R4 drain");
    step(1'b0, 0, 0, 1'b1, "R5 fall through");
    step(1'b0, 0, 0, 1'b1, "R6 idle branch");
    step(1'b0, 0, 0, 1'b0, "R6 idle branch");
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule